// File: doc/BRIEF.md
# Color Gain Steering Controller

This block sits beside the sampling path of an image sensor front end. For every accepted pixel it picks one of four programmable 6-bit gain codes, so that each color site of the sensor's filter mosaic gets its own gain. The pick follows three parities: pixel parity within the line, line parity within the frame, and field parity across frames. These are recovered from the pixel strobe and from the rising edges of the horizontal (`hd`) and vertical (`vd`) sync inputs.

A 3-bit mode input sets how the parities map onto the four gain slots. The mosaic mode uses pixel parity and line parity. The interlaced mode uses pixel parity and field parity. All other codes turn steering off. Gain codes are written through a plain write port into staging registers, and they reach the pixel path only at a line boundary.

The pixel stream has no back-pressure. The sensor sets the pixel rate, so the block has no ready input. Each cycle with `pix_valid` high yields exactly one result, with `gain_valid` high on the next cycle, and the consumer must take it in that cycle. The result outputs hold their value while `gain_valid` is low.

Top module: `color_gain_steer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `gain_valid`, `gain_sel` and `gain_code` are 0. All four staging slots and all four live gain slots start at 0.
- R2: With mode 3'b001 (mosaic), the slot index is {line parity, pixel parity}. Line 0 gives slots 0,1,0,1,… and line 1 gives slots 2,3,2,3,…
- R3: With mode 3'b010 (interlaced), the slot index is {field parity, pixel parity}. Field parity is 1 out of reset and inverts on every `vd` rising edge.
- R4: With mode 3'b000 or any code from 3'b011 to 3'b111, every pixel gets slot 0 and the code of live slot 0.
- R5: Pixel parity advances only on cycles with `pix_valid` high, so idle cycles leave it unchanged. A pixel in the same cycle as an `hd` or `vd` rising edge is pixel 0, which is even.
- R6: An `hd` rising edge inverts line parity. A `vd` rising edge makes the pixel in that cycle, and the rest of that line, line 0. When both edges fall in one cycle, the result is line 0.
- R7: A write (`wr_en`, `wr_addr` is the slot number, `wr_data`) updates only the staging slot. The staging slots are copied to the live slots on an `hd` rising edge, and a pixel in that same cycle already uses the new values. A write in the same cycle as the edge is not copied until the next `hd` rising edge.
- R8: `gain_valid` is `pix_valid` delayed by one cycle. When it is high, `gain_sel` is the slot chosen for that pixel and `gain_code` is that slot's live code. Both hold their value when no pixel is accepted.
- R9: Only rising edges of `hd` and `vd` count. A sync input held high for several cycles acts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel accepted this cycle |
| hd | input | 1 | Horizontal sync, rising edge starts a line |
| vd | input | 1 | Vertical sync, rising edge starts a frame/field |
| mode | input | 3 | Steering mode: 001 mosaic, 010 interlaced, others off |
| wr_en | input | 1 | Gain staging write strobe |
| wr_addr | input | 2 | Slot number to write |
| wr_data | input | 6 | Gain code to write |
| gain_valid | output | 1 | Result valid, one cycle after `pix_valid` |
| gain_code | output | 6 | Selected gain code |
| gain_sel | output | 2 | Index of the selected slot |

## Verification
Several events can fall in the same cycle: a pixel, an `hd` edge, a `vd` edge and a register write. The bench provokes each of these pairings on purpose. It sends a pixel together with a joint `hd`/`vd` edge, which must give line 0, pixel 0 and freshly copied gains. It also sends a write in the same cycle as an `hd` edge, and that write must stay out of the live slots until the following line. Each pixel's expected slot and code come from a reference model that the driver updates from the requirements. A monitor compares these against every `gain_valid` result in order.

// File: rtl/csteer_pkg.sv
package csteer_pkg;
  localparam int NUM_GAINS = 4;
  localparam int SEL_W     = $clog2(NUM_GAINS);

  localparam logic [2:0] MODE_OFF   = 3'b000;
  localparam logic [2:0] MODE_PROG  = 3'b001;
  localparam logic [2:0] MODE_FIELD = 3'b010;

  // Map the three parities onto a slot index for the given mode.
  function automatic logic [SEL_W-1:0] pick_sel(input logic [2:0] mode,
                                                 input logic pix,
                                                 input logic line,
                                                 input logic field);
    logic [SEL_W-1:0] s;
    case (mode)
      MODE_PROG:  s = {line, pix};
      MODE_FIELD: s = {field, pix};
      default:    s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/csteer_edge.sv
module csteer_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/csteer_parity.sv
module csteer_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_valid,
  input  logic hd_rise,
  input  logic vd_rise,
  output logic pix_now,
  output logic line_now,
  output logic field_now
);
  logic pix_q, line_q, field_q;

  // Parities that apply to a pixel arriving in the current cycle.
  always_comb begin
    pix_now   = (hd_rise || vd_rise) ? 1'b0 : pix_q;
    line_now  = vd_rise ? 1'b0 : (hd_rise ? ~line_q : line_q);
    field_now = vd_rise ? ~field_q : field_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q   <= 1'b0;
      line_q  <= 1'b0;
      field_q <= 1'b1;
    end else begin
      pix_q   <= pix_now ^ pix_valid;
      line_q  <= line_now;
      field_q <= field_now;
    end
  end

  // R5: idle cycles without sync edges keep pixel parity
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !hd_rise && !vd_rise) |=> $stable(pix_q));

  // R6: vertical edge leaves line 0 in place
  a_r6_vd_line0: assert property (@(posedge clk) disable iff (!rst_n)
    vd_rise |=> (line_q == 1'b0));

  // R6: lone horizontal edge flips line parity
  a_r6_hd_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_rise && !vd_rise) |=> (line_q != $past(line_q)));

  // R3: field parity moves only on a vertical edge
  a_r3_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_rise |=> $stable(field_q));

  a_r3_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    vd_rise |=> (field_q != $past(field_q)));
endmodule

// File: rtl/csteer_gainbank.sv
module csteer_gainbank
  import csteer_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic              load,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [GAIN_W-1:0] rd_code
);
  logic [GAIN_W-1:0] stage_q [NUM_GAINS];
  logic [GAIN_W-1:0] live_q  [NUM_GAINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GAINS; i++) begin
        stage_q[i] <= '0;
        live_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_GAINS; i++) begin
        if (wr_en && (wr_addr == SEL_W'(i))) stage_q[i] <= wr_data;
        if (load) live_q[i] <= stage_q[i];
      end
    end
  end

  // A pixel on the load cycle already sees the staged values.
  assign rd_code = load ? stage_q[rd_sel] : live_q[rd_sel];

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_chk
    // R7: live slot frozen between line boundaries
    a_r7_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(live_q[g]));
    // R7: boundary copies staging as it stood before the edge cycle's write
    a_r7_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (live_q[g] == $past(stage_q[g])));
  end
endmodule

// File: rtl/color_gain_steer.sv
module color_gain_steer
  import csteer_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              hd,
  input  logic              vd,
  input  logic [2:0]        mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  output logic              gain_valid,
  output logic [GAIN_W-1:0] gain_code,
  output logic [SEL_W-1:0]  gain_sel
);
  logic [1:0]        rise;
  logic              hd_rise, vd_rise;
  logic              pix_now, line_now, field_now;
  logic [SEL_W-1:0]  sel_now;
  logic [GAIN_W-1:0] code_now;

  csteer_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({vd, hd}),
    .rise (rise)
  );
  assign hd_rise = rise[0];
  assign vd_rise = rise[1];

  csteer_parity u_parity (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_valid(pix_valid),
    .hd_rise  (hd_rise),
    .vd_rise  (vd_rise),
    .pix_now  (pix_now),
    .line_now (line_now),
    .field_now(field_now)
  );

  assign sel_now = pick_sel(mode, pix_now, line_now, field_now);

  csteer_gainbank #(.GAIN_W(GAIN_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .load   (hd_rise),
    .rd_sel (sel_now),
    .rd_code(code_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_valid <= 1'b0;
      gain_sel   <= '0;
      gain_code  <= '0;
    end else begin
      gain_valid <= pix_valid;
      if (pix_valid) begin
        gain_sel  <= sel_now;
        gain_code <= code_now;
      end
    end
  end

  // R4: steering off or reserved codes force slot 0
  a_r4_off_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode != MODE_PROG && mode != MODE_FIELD) |=> (gain_sel == '0));

  // R5: a pixel sharing a cycle with a sync edge is even
  a_r5_edge_even: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (hd_rise || vd_rise)) |=> !gain_sel[0]);

  // R2: mosaic frame starts on slot 0
  a_r2_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && vd_rise && mode == MODE_PROG) |=> (gain_sel == '0));

  // R8: results hold while no pixel is accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(gain_sel) && $stable(gain_code)));
endmodule

// File: tb/test_color_gain_steer.sv
module test_color_gain_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0, hd = 1'b0, vd = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       gain_valid;
  logic [5:0] gain_code;
  logic [1:0] gain_sel;

  always #5 clk = ~clk;

  color_gain_steer #(.GAIN_W(6)) i_color_gain_steer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hd(hd), .vd(vd),
    .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_valid(gain_valid), .gain_code(gain_code), .gain_sel(gain_sel)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // reference model state
  logic       m_hdq = 0, m_vdq = 0, m_pix = 0, m_line = 0, m_field = 1;
  logic [5:0] m_stage[4] = '{default: 6'd0};
  logic [5:0] m_live[4]  = '{default: 6'd0};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus plus model update
  task automatic cyc(input logic pv, input logic h, input logic v,
                     input logic we = 1'b0, input logic [1:0] wa = 2'd0,
                     input logic [5:0] wd = 6'd0, input string tag = "R8");
    logic hr, vr, ep, el, ef;
    logic [1:0] s;
    logic [5:0] eg[4];
    @(negedge clk);
    pix_valid = pv; hd = h; vd = v; wr_en = we; wr_addr = wa; wr_data = wd;
    hr = h & ~m_hdq;
    vr = v & ~m_vdq;
    ep = (hr || vr) ? 1'b0 : m_pix;
    el = vr ? 1'b0 : (hr ? ~m_line : m_line);
    ef = vr ? ~m_field : m_field;
    for (int i = 0; i < 4; i++) eg[i] = hr ? m_stage[i] : m_live[i];
    if (mode == 3'b001)      s = {el, ep};
    else if (mode == 3'b010) s = {ef, ep};
    else                     s = 2'd0;
    if (pv) begin
      exp_q.push_back({s, eg[s]});
      tag_q.push_back(tag);
    end
    m_pix = ep ^ pv; m_line = el; m_field = ef;
    for (int i = 0; i < 4; i++) m_live[i] = eg[i];
    if (we) m_stage[wa] = wd;
    m_hdq = h; m_vdq = v;
  endtask

  // one line: sync edge with the first pixel, n pixels, then an idle cycle
  task automatic line(input int n, input logic v, input string tag);
    cyc(1'b1, 1'b1, v, 1'b0, 2'd0, 6'd0, tag);
    for (int k = 1; k < n; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0, tag);
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && gain_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", {gain_sel, gain_code}, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({gain_sel, gain_code} == e, t, {gain_sel, gain_code}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gain_valid == 1'b0, "R1 valid", gain_valid, 0);
    check(gain_sel == 2'd0, "R1 sel", gain_sel, 0);
    check(gain_code == 6'd0, "R1 code", gain_code, 0);
    rst_n = 1'b1;
    #1;
    check(gain_valid == 1'b0 && gain_code == 6'd0, "R1 after release", gain_code, 0);

    mode = 3'b001;
    cyc(0, 0, 0, 1, 2'd0, 6'd10);
    cyc(0, 0, 0, 1, 2'd1, 6'd21);
    cyc(0, 0, 0, 1, 2'd2, 6'd42);
    cyc(0, 0, 0, 1, 2'd3, 6'd63);
    // R7: staged values not live before an hd edge
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R7 staged not live");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R7 staged not live");
    cyc(0, 0, 0);
    // R6: joint vd+hd edge gives line 0, pixel 0
    cyc(1, 1, 1, 0, 2'd0, 6'd0, "R6 joint edge");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R2 mosaic line0");
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R5 idle gap");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R2 mosaic line0");
    cyc(1, 1, 0, 0, 2'd0, 6'd0, "R6 hd advance");
    cyc(1, 1, 0, 0, 2'd0, 6'd0, "R9 hd held high");
    cyc(1, 1, 0, 0, 2'd0, 6'd0, "R9 hd held high");
    cyc(0, 0, 0);
    line(4, 1'b0, "R2 mosaic line0 again");
    line(5, 1'b0, "R2 mosaic line1");

    // R7: write in the same cycle as an hd edge
    cyc(0, 0, 0, 1, 2'd1, 6'd7);
    cyc(1, 1, 0, 1, 2'd0, 6'd33, "R7 edge load");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R7 edge load");
    cyc(0, 0, 0);
    line(4, 1'b0, "R7 late write applied");

    // R6: vd alone mid-line
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R6 before vd");
    cyc(1, 0, 1, 0, 2'd0, 6'd0, "R6 vd mid-line");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R6 after vd");
    cyc(0, 0, 0);

    // R3: interlaced fields
    mode = 3'b010;
    line(4, 1'b1, "R3 field");
    line(4, 1'b0, "R3 field same");
    line(3, 1'b1, "R3 field next");
    line(3, 1'b0, "R3 field same");
    cyc(1, 0, 1, 0, 2'd0, 6'd0, "R9 vd held");
    cyc(1, 0, 1, 0, 2'd0, 6'd0, "R9 vd held");
    cyc(1, 0, 0, 0, 2'd0, 6'd0, "R9 vd held");
    cyc(0, 0, 0);

    // R4: steering off and reserved codes
    mode = 3'b000; line(4, 1'b0, "R4 mode off");
    mode = 3'b011; line(3, 1'b1, "R4 reserved 3");
    mode = 3'b111; line(3, 1'b0, "R4 reserved 7");

    repeat (4) cyc(0, 0, 0);
    check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule